// File: doc/BRIEF.md
# Hardware/Software Clock Gate Controller

This block decides whether a downstream clock is enabled. A small control register chooses the owner of the gate. Either software drives it through an enable field, or an external hardware request input drives it. When the gate is asked to close, an optional turn-off delay keeps it open for a short or a long number of reference cycles. A read-only status field reports the state the gate is really in, so software can poll it after changing the enable field. A build-time variant makes the gate stay on under software ownership even when the enable field holds 0.

The gate is controlled by a three-state machine: `GATE_OFF`, `GATE_ON` and `GATE_HOLD`, where `GATE_HOLD` is the turn-off delay. The transitions are:
- `GATE_OFF` to `GATE_ON` when demand is present (turn-on).
- `GATE_ON` to `GATE_HOLD` when demand drops and the delay is enabled (start delay).
- `GATE_ON` to `GATE_OFF` when demand drops and the delay is disabled (direct off).
- `GATE_HOLD` to `GATE_ON` when demand returns (cancel).
- `GATE_HOLD` to `GATE_OFF` when the count expires or the delay is disabled (expire).

Demand is the software enable field (or the forced-on variant) under software ownership, and `hw_req` under hardware ownership. The output `clk_en` is meant to drive a separate clock buffer cell.

Top module: `clk_gate_ctl`

## Requirements
- R1: After reset `clk_en` is 0 and `reg_rdata` reads 0x00. The control fields are 0, so hardware owns the gate and there is no delay.
- R2: With bit 0 (owner select) at 0, `clk_en` follows `hw_req`. It rises on the first clock edge after `hw_req` is seen high.
- R3: With bit 0 at 1, `clk_en` follows bit 1 (software enable) and `hw_req` has no effect on it.
- R4: Bit 4 of `reg_rdata` reads the current value of `clk_en`.
- R5: With bit 2 (delay enable) at 0, `clk_en` falls on the first clock edge after demand is removed.
- R6: With bit 2 at 1 and bit 3 (delay length) at 0, `clk_en` falls exactly LO_DLY+1 edges after demand is removed.
- R7: With bits 2 and 3 both at 1, `clk_en` falls exactly HI_DLY+1 edges after demand is removed.
- R8: Demand that returns during the turn-off delay cancels it. `clk_en` stays 1 without a gap, and a later removal starts a fresh full delay.
- R9: With KEEP_ON=1 under software ownership, `clk_en` is 1 while bit 1 reads back 0. Under hardware ownership the variant follows `hw_req` as usual.
- R10: Writes to bit 4 and to bits 7:5 have no effect. Bits 7:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Register read value, including the status bit |
| hw_req | input | 1 | Hardware request, used under hardware ownership |
| clk_en | output | 1 | Gate enable for the clock buffer |

## Verification
The bench uses LO_DLY=3 and HI_DLY=7. These are short and distinct, so the exact edge on which `clk_en` falls for each delay setting can be counted, and a cancel in the middle of a delay is easy to place. A second instance is built with KEEP_ON=1. Its forced-on behaviour and its read-back of 0 in the enable field are checked beside the ordinary instance, which has KEEP_ON=0.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_ON   = 2'd1,
        GATE_HOLD = 2'd2
    } gate_state_t;

    localparam int F_OWNER  = 0;
    localparam int F_SWON   = 1;
    localparam int F_DLYEN  = 2;
    localparam int F_DLYLNG = 3;
    localparam int F_STATUS = 4;
endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
    import clkgate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status,
    output logic              sw_own,
    output logic              sw_on,
    output logic              dly_en,
    output logic              dly_long,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_own   <= 1'b0;
            sw_on    <= 1'b0;
            dly_en   <= 1'b0;
            dly_long <= 1'b0;
        end else if (we) begin
            sw_own   <= wdata[F_OWNER];
            sw_on    <= wdata[F_SWON];
            dly_en   <= wdata[F_DLYEN];
            dly_long <= wdata[F_DLYLNG];
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[F_OWNER]  = sw_own;
        rdata[F_SWON]   = sw_on;
        rdata[F_DLYEN]  = dly_en;
        rdata[F_DLYLNG] = dly_long;
        rdata[F_STATUS] = status;
    end
endmodule

// File: rtl/clkgate_fsm.sv
module clkgate_fsm
    import clkgate_pkg::*;
#(
    parameter int LO_DLY = 4,
    parameter int HI_DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic demand,
    input  logic dly_en,
    input  logic dly_long,
    output logic gate_on
);
    localparam int CW = $clog2(HI_DLY + 1);
    localparam logic [CW-1:0] LO_LOAD = CW'(LO_DLY - 1);
    localparam logic [CW-1:0] HI_LOAD = CW'(HI_DLY - 1);

    gate_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GATE_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            GATE_OFF: begin
                if (demand) state_nx = GATE_ON;
            end
            GATE_ON: begin
                if (!demand) begin
                    if (dly_en) begin
                        state_nx = GATE_HOLD;
                        cnt_nx   = dly_long ? HI_LOAD : LO_LOAD;
                    end else begin
                        state_nx = GATE_OFF;
                    end
                end
            end
            GATE_HOLD: begin
                if (demand)
                    state_nx = GATE_ON;
                else if (!dly_en || cnt == '0)
                    state_nx = GATE_OFF;
                else
                    cnt_nx = cnt - 1'b1;
            end
            default: state_nx = GATE_OFF;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            GATE_ON, GATE_HOLD: gate_on = 1'b1;
            default:            gate_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl
    import clkgate_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LO_DLY  = 4,
    parameter int HI_DLY  = 16,
    parameter bit KEEP_ON = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hw_req,
    output logic              clk_en
);
    logic sw_own, sw_on, dly_en, dly_long, sw_demand, demand, gate_on;

    clkgate_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
        .status(gate_on), .sw_own(sw_own), .sw_on(sw_on),
        .dly_en(dly_en), .dly_long(dly_long), .rdata(reg_rdata)
    );

    generate
        if (KEEP_ON) begin : g_keep
            assign sw_demand = 1'b1;
        end else begin : g_norm
            assign sw_demand = sw_on;
        end
    endgenerate

    assign demand = sw_own ? sw_demand : hw_req;

    clkgate_fsm #(.LO_DLY(LO_DLY), .HI_DLY(HI_DLY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .demand(demand),
        .dly_en(dly_en), .dly_long(dly_long), .gate_on(gate_on)
    );

    assign clk_en = gate_on;
endmodule

// File: rtl/clk_gate_ctl_chk.sv
module clk_gate_ctl_chk #(
    parameter int DATA_W  = 8,
    parameter int HI_DLY  = 16,
    parameter bit KEEP_ON = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_req,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              clk_en
);
    localparam int RW = $clog2(HI_DLY + 3) + 1;
    logic want;
    logic [RW-1:0] run;

    assign want = reg_rdata[0] ? (reg_rdata[1] | KEEP_ON) : hw_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= '0;
        else if (clk_en && !want) run <= run + 1'b1;
        else run <= '0;
    end

    // R2
    turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        want |=> clk_en);

    // R5
    direct_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !want && !reg_rdata[2]) |=> !clk_en);

    // R7
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(HI_DLY + 1));

    // R9
    keep_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (KEEP_ON && reg_rdata[0]) |=> clk_en);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:5] == '0);
endmodule

bind clk_gate_ctl clk_gate_ctl_chk #(.DATA_W(DATA_W), .HI_DLY(HI_DLY), .KEEP_ON(KEEP_ON)) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_rdata(reg_rdata), .clk_en(clk_en)
);

// File: tb/clk_gate_ctl_test.sv
module clk_gate_ctl_test;
    localparam int LO = 3;
    localparam int HI = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req = 1'b0;
    logic we = 1'b0, we_nd = 1'b0;
    logic [7:0] wd = '0, wd_nd = '0;
    logic [7:0] rd, rd_nd;
    logic en, en_nd;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    clk_gate_ctl #(.DATA_W(8), .LO_DLY(LO), .HI_DLY(HI), .KEEP_ON(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_wdata(wd),
        .reg_rdata(rd), .hw_req(hw_req), .clk_en(en));

    clk_gate_ctl #(.DATA_W(8), .LO_DLY(LO), .HI_DLY(HI), .KEEP_ON(1'b1)) uut_nd (
        .clk(clk), .rst_n(rst_n), .reg_we(we_nd), .reg_wdata(wd_nd),
        .reg_rdata(rd_nd), .hw_req(hw_req), .clk_en(en_nd));

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); we = 1'b1; wd = v;
        @(negedge clk); we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_nd(input logic [7:0] v);
        @(negedge clk); we_nd = 1'b1; wd_nd = v;
        @(negedge clk); we_nd = 1'b0;
        @(negedge clk);
    endtask

    task automatic measure_off(output int n);
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            n++;
            if (!en) break;
        end
    endtask

    task automatic t_reset();
        check(en == 1'b0, "R1 clk_en", int'(en), 0);
        check(rd == 8'h00, "R1 rdata", int'(rd), 0);
    endtask

    task automatic t_hw();
        @(negedge clk); hw_req = 1'b1;
        @(negedge clk);
        check(en == 1'b1, "R2 on", int'(en), 1);
        check(rd[4] == 1'b1, "R4 status on", int'(rd[4]), 1);
        hw_req = 1'b0;
        @(negedge clk);
        check(en == 1'b0, "R5 off", int'(en), 0);
        check(rd[4] == 1'b0, "R4 status off", int'(rd[4]), 0);
    endtask

    task automatic t_sw();
        wr(8'h03);
        check(en == 1'b1, "R3 sw on", int'(en), 1);
        hw_req = 1'b0;
        repeat (2) @(negedge clk);
        check(en == 1'b1, "R3 hw_req ignored on", int'(en), 1);
        wr(8'h01);
        check(en == 1'b0, "R3 sw off", int'(en), 0);
        hw_req = 1'b1;
        repeat (2) @(negedge clk);
        check(en == 1'b0, "R3 hw_req ignored off", int'(en), 0);
        hw_req = 1'b0;
        wr(8'h00);
    endtask

    task automatic t_delay(input logic lng, input int d, input string tag);
        int n;
        wr(lng ? 8'h0C : 8'h04);
        @(negedge clk); hw_req = 1'b1;
        @(negedge clk); hw_req = 1'b0;
        measure_off(n);
        check(n == d + 1, tag, n, d + 1);
    endtask

    task automatic t_cancel();
        int n;
        logic gap;
        wr(8'h04);
        @(negedge clk); hw_req = 1'b1;
        @(negedge clk); hw_req = 1'b0;
        @(negedge clk);
        check(en == 1'b1, "R8 in hold", int'(en), 1);
        hw_req = 1'b1;
        gap = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!en) gap = 1'b1;
        end
        check(gap == 1'b0, "R8 no gap", int'(gap), 0);
        hw_req = 1'b0;
        measure_off(n);
        check(n == LO + 1, "R8 fresh delay", n, LO + 1);
        wr(8'h00);
    endtask

    task automatic t_keep();
        wr_nd(8'h01);
        check(en_nd == 1'b1, "R9 forced on", int'(en_nd), 1);
        check(rd_nd[1] == 1'b0, "R9 enable reads 0", int'(rd_nd[1]), 0);
        check(rd_nd[4] == 1'b1, "R9 status", int'(rd_nd[4]), 1);
        wr_nd(8'h00);
        @(negedge clk);
        check(en_nd == 1'b0, "R9 hw mode off", int'(en_nd), 0);
    endtask

    task automatic t_reserved();
        hw_req = 1'b0;
        wr(8'hF0);
        @(negedge clk);
        check(rd == 8'h00, "R10 reserved and status", int'(rd), 0);
        check(en == 1'b0, "R10 gate", int'(en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hw();
        t_sw();
        t_delay(1'b0, LO, "R6 short delay");
        t_delay(1'b1, HI, "R7 long delay");
        t_cancel();
        t_keep();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule